// File: doc/BRIEF.md
# Single-RAM Ping-Pong Packet Buffer

This block is a double buffer for whole packets, built on one simple dual-port RAM that has one write port and one read port. The RAM is split into two equal halves by its top address bit. A producer fills one half with a packet while a consumer drains the other half. When each side finishes its half, it moves to the other half, so the halves swap roles packet by packet.

Each half has its own state: empty, filling, full or draining. It also keeps a count of the words stored in it. The writer selects a half with its own section bit and offset counter. The reader does the same. Each RAM port therefore addresses its own half, and a write and a read can happen in the same cycle.

Both edges of the block are valid/ready streams. A word moves on a cycle where valid and ready are both high. On the input side, `in_ready` drops whenever the writer's half is not free to fill. The producer must then hold `in_data` and `in_last` until the word is taken. On the output side, the consumer may hold `out_ready` low for any number of cycles, and the presented word stays unchanged while it does.

Top module: `pp_pkt_buf`

## Requirements
- R1: After reset, both halves are empty, `in_ready` is 1 and `out_valid` is 0.
- R2: Words leave in the order they were accepted, and their data is unchanged.
- R3: A half is closed by a word accepted with `in_last`=1, or by its HALF_DEPTH-th word, whichever comes first. The stored word count of that half is read back, and `out_last` is 1 only on its final word. A packet longer than HALF_DEPTH therefore leaves as chunks of HALF_DEPTH words, and each chunk ends with `out_last`.
- R4: `out_valid` stays 0 until at least one half has been closed. Words of a half that is still being filled are never presented.
- R5: While both halves hold packets that have not been read out, `in_ready` is 0.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R7: With one closed half waiting and the consumer stalled, `in_ready` stays 1, so the other half can be filled while the first one waits to be drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer has a word |
| in_ready | output | 1 | Writer's half can take a word |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Final word of the input packet |
| out_valid | output | 1 | Output word is presented |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final stored word of a half |

## Verification
The checker assumes that the producer keeps to valid/ready rules and that reset is applied before traffic starts. It keeps its own count of closed packets that have not yet been read out. That count is built from the input close rule (last marker or HALF_DEPTH words) and from output handshakes that carry `out_last`. The stimulus drives inputs only on the falling edge and holds each word until it is taken. It sends random-length packets, some longer than HALF_DEPTH, with random stalls on both sides. Directed phases keep the consumer stalled so that the two-half limit and the case of a half that is still filling are both reached.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
  typedef enum logic [1:0] {
    HS_EMPTY    = 2'd0,
    HS_FILLING  = 2'd1,
    HS_FULL     = 2'd2,
    HS_DRAINING = 2'd3
  } half_st_t;
endpackage

// File: rtl/pp_sdp_ram.sv
module pp_sdp_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read; output holds while re is low.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_half_ctl.sv
module pp_half_ctl
  import pp_buf_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fire,
  input  logic             wr_close,
  input  logic [CNT_W-1:0] close_cnt,
  input  logic             rd_fire,
  input  logic             rd_close,
  output half_st_t         st,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= HS_EMPTY;
      cnt <= '0;
    end else begin
      unique case (st)
        HS_EMPTY:    if (wr_fire) st <= wr_close ? HS_FULL : HS_FILLING;
        HS_FILLING:  if (wr_fire && wr_close) st <= HS_FULL;
        HS_FULL:     if (rd_fire) st <= rd_close ? HS_EMPTY : HS_DRAINING;
        HS_DRAINING: if (rd_fire && rd_close) st <= HS_EMPTY;
        default:     st <= HS_EMPTY;
      endcase
      if (wr_fire && wr_close) cnt <= close_cnt;
    end
  end
endmodule

// File: rtl/pp_wr_side.sv
module pp_wr_side
  import pp_buf_pkg::*;
#(
  parameter int HALF_DEPTH = 16,
  parameter int OFF_W      = 4,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  half_st_t         cur_st,
  output logic             in_ready,
  output logic             wsel,
  output logic [OFF_W-1:0] woff,
  output logic             fire,
  output logic             close,
  output logic [CNT_W-1:0] close_cnt
);
  assign in_ready  = (cur_st == HS_EMPTY) || (cur_st == HS_FILLING);
  assign fire      = in_valid && in_ready;
  assign close     = in_last || (woff == OFF_W'(HALF_DEPTH - 1));
  assign close_cnt = CNT_W'(woff) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel <= 1'b0;
      woff <= '0;
    end else if (fire) begin
      if (close) begin
        wsel <= ~wsel;
        woff <= '0;
      end else begin
        woff <= woff + OFF_W'(1);
      end
    end
  end
endmodule

// File: rtl/pp_rd_side.sv
module pp_rd_side
  import pp_buf_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  half_st_t         cur_st,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             rsel,
  output logic [OFF_W-1:0] roff,
  output logic             fire,
  output logic             close
);
  logic readable;

  assign readable = (cur_st == HS_FULL) || (cur_st == HS_DRAINING);
  assign fire     = readable && (!out_valid || out_ready);
  assign close    = (CNT_W'(roff) + CNT_W'(1)) == cur_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel      <= 1'b0;
      roff      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_last  <= close;
        if (close) begin
          rsel <= ~rsel;
          roff <= '0;
        end else begin
          roff <= roff + OFF_W'(1);
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pp_pkt_buf.sv
module pp_pkt_buf
  import pp_buf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int HALF_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  localparam int OFF_W  = (HALF_DEPTH > 1) ? $clog2(HALF_DEPTH) : 1;
  localparam int CNT_W  = OFF_W + 1;
  localparam int ADDR_W = OFF_W + 1;

  half_st_t         hst [2];
  logic [CNT_W-1:0] hcnt [2];

  logic             wsel, rsel, wfire, wclose, rfire, rclose;
  logic [OFF_W-1:0] woff, roff;
  logic [CNT_W-1:0] wcnt;

  pp_wr_side #(.HALF_DEPTH(HALF_DEPTH), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .cur_st(hst[wsel]), .in_ready(in_ready), .wsel(wsel), .woff(woff),
    .fire(wfire), .close(wclose), .close_cnt(wcnt)
  );

  pp_rd_side #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .cur_st(hst[rsel]), .cur_cnt(hcnt[rsel]),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .rsel(rsel), .roff(roff), .fire(rfire), .close(rclose)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_half
    logic mine_w, mine_r;
    assign mine_w = (wsel == 1'(gi));
    assign mine_r = (rsel == 1'(gi));
    pp_half_ctl #(.CNT_W(CNT_W)) u_half (
      .clk(clk), .rst(rst),
      .wr_fire(wfire && mine_w), .wr_close(wclose), .close_cnt(wcnt),
      .rd_fire(rfire && mine_r), .rd_close(rclose),
      .st(hst[gi]), .cnt(hcnt[gi])
    );
  end

  pp_sdp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wfire), .waddr({wsel, woff}), .wdata(in_data),
    .re(rfire), .raddr({rsel, roff}), .rdata(out_data)
  );
endmodule

// File: rtl/pp_pkt_buf_chk.sv
module pp_pkt_buf_chk #(
  parameter int DATA_W     = 16,
  parameter int HALF_DEPTH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last
);
  localparam int CW = $clog2(HALF_DEPTH + 1) + 1;
  logic [CW-1:0] words_in;
  logic [2:0]    pending;
  logic          in_hs, in_close, out_close;

  assign in_hs     = in_valid && in_ready;
  assign in_close  = in_hs && (in_last || (words_in == CW'(HALF_DEPTH - 1)));
  assign out_close = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      words_in <= '0;
      pending  <= '0;
    end else begin
      if (in_close)   words_in <= '0;
      else if (in_hs) words_in <= words_in + CW'(1);
      pending <= pending + 3'(in_close) - 3'(out_close);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R4
  no_early_read_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pending != 3'd0));

  // R5
  both_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (pending >= 3'd3) |-> !in_ready);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind pp_pkt_buf pp_pkt_buf_chk #(.DATA_W(DATA_W), .HALF_DEPTH(HALF_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/sim_pp_pkt_buf.sv
module sim_pp_pkt_buf;
  localparam int DW = 16;
  localparam int HD = 8;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [DW-1:0] out_data;

  int total = 0, bad = 0;
  int rd_prob = 0;
  int wcount = 0;
  logic [DW-1:0] exp_d [$];
  logic          exp_l [$];
  logic          hold_pend = 0;
  logic [DW-1:0] hold_d;
  logic          hold_l;
  bit            finished = 0;

  always #2 clk = ~clk;

  pp_pkt_buf #(.DATA_W(DW), .HALF_DEPTH(HD)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit closes(bit l, int cnt);
    return l || (cnt == HD - 1);
  endfunction

  // caller sits at a falling edge
  task automatic put(logic [DW-1:0] d, bit l);
    in_valid = 1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    exp_d.push_back(d);
    exp_l.push_back(closes(l, wcount));
    wcount = closes(l, wcount) ? 0 : wcount + 1;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic send_pkt(int len, int stall_pct);
    for (int i = 0; i < len; i++) begin
      while (($urandom % 100) < stall_pct) @(negedge clk);
      put(DW'($urandom), i == len - 1);
    end
  endtask

  // consumer: decide ready, then score the handshake that the next edge takes
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (hold_pend) begin
        check(out_valid && out_data == hold_d && out_last == hold_l,
              "R6 hold", int'(out_data), int'(hold_d));
      end
      out_ready = (($urandom % 100) < rd_prob);
      hold_pend = out_valid && !out_ready;
      hold_d = out_data; hold_l = out_last;
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          check(0, "R2 unexpected word", int'(out_data), -1);
        end else begin
          check(out_data == exp_d[0], "R2 data", int'(out_data), int'(exp_d[0]));
          check(out_last == exp_l[0], "R3 last", int'(out_last), int'(exp_l[0]));
          void'(exp_d.pop_front());
          void'(exp_l.pop_front());
        end
      end
    end
  end

  task automatic drain();
    rd_prob = 100;
    for (int i = 0; i < 2000 && (exp_d.size() != 0 || out_valid); i++) @(negedge clk);
    check(exp_d.size() == 0, "R2 drained", exp_d.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready == 1, "R1 in_ready", in_ready, 1);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    rst = 0;
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0, "R1 after release", out_valid, 0);

    // R4: partial packet is invisible
    rd_prob = 0;
    for (int i = 0; i < 3; i++) put(DW'(16'hA0 + i), 0);
    repeat (5) @(negedge clk);
    check(out_valid == 0, "R4 no early read", out_valid, 0);
    put(16'hA3, 1);
    repeat (3) @(negedge clk);
    check(out_valid == 1, "R4 valid after close", out_valid, 1);
    // R7: other half still fillable
    check(in_ready == 1, "R7 second half free", in_ready, 1);
    // R5: fill second half, then both busy
    send_pkt(2, 0);
    repeat (3) @(negedge clk);
    check(in_ready == 0, "R5 both halves busy", in_ready, 0);
    repeat (4) @(negedge clk);
    check(out_valid == 1, "R6 still presented", out_valid, 1);
    drain();

    // R3: long packet splits, one-word packet
    rd_prob = 50;
    send_pkt(HD * 2 + 3, 10);
    send_pkt(1, 0);
    send_pkt(HD, 0);
    drain();

    // R2: random traffic
    rd_prob = 70;
    for (int p = 0; p < 60; p++) send_pkt(1 + ($urandom % 20), $urandom % 40);
    drain();
    rd_prob = 100;
    for (int p = 0; p < 20; p++) send_pkt(1 + ($urandom % 10), 0);
    drain();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule